// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Status Flags

This block receives asynchronous serial frames on one line and turns them into bytes that a host collects through a small register bus. Each frame has one start bit, eight data bits sent least significant bit first, an optional parity bit that can be set to even or odd, and one stop bit. The line is oversampled sixteen times per bit. The oversampling rate comes from a divider input: one sample tick every `baud_div_i + 1` clock cycles. A finished byte goes into a data register, and a full flag is raised with a one-cycle interrupt pulse.

The host services a byte in three steps. It reads the status register and sees the full flag set. It reads the data register. It then writes the full flag back to zero. A transfer controller can do the same job in one step: it pulses an acknowledge input, and that clears the full flag with no software write. The block has three error flags: overrun, parity and framing. While any of them is set, finished frames are thrown away until software clears every error flag. The status register also shows the synchronized line level, so that after a framing error software can tell a line held low (a break) from noise.

Register map. Address 0 is control: bit 0 receive enable, bit 1 parity enable, bit 2 odd parity. Address 1 is status: bit 0 full, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 7 line level, all other bits 0. Address 2 is the received data. Address 3 reads as 0.

Top module: `srx_channel`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, `irq_o` is 0, and the status register reads 0x80 while the line is held high.
- R2: When enabled, a frame with a valid start bit, eight LSB-first data bits and a stop bit of 1, arriving while the full flag and all error flags are 0, places its byte in the data register and sets the full flag (status bit 0).
- R3: `irq_o` pulses high for exactly one cycle each time the full flag goes from 0 to 1.
- R4: A status flag clears only when 0 is written to its bit after that flag has been read as 1. Writing 1 has no effect. Writing 0 with no earlier read of the flag as 1 also has no effect.
- R5: A frame that completes with no parity or framing error while the full flag is 1 sets the overrun flag (bit 1) and leaves the data register unchanged.
- R6: While any error flag is 1, finished frames change neither the data register nor the full flag.
- R7: With parity enabled (control bit 1), the parity bit follows the data bits. Even parity (control bit 2 = 0) needs an even number of ones across data and parity. Odd parity (bit 2 = 1) needs an odd number. A mismatch sets the parity error flag (bit 2) and the byte is not stored.
- R8: A stop bit sampled as 0 sets the framing error flag (bit 3) and the byte is not stored.
- R9: A one-cycle pulse on `dma_ack_i` clears the full flag without any register write.
- R10: With receive enable (control bit 0) at 0, frames on the line have no effect on the flags or the data register.
- R11: A low pulse shorter than half a bit is rejected as a glitch and leaves the receiver idle, ready for the next real frame.
- R12: Status bit 7 shows the synchronized line level, including while the line is held low after a framing error.
- R13: If the full flag is cleared before the next frame's stop bit is sampled, that next frame is stored with no overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| baud_div_i | input | 16 | Oversampling tick period minus one, in clock cycles |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_o | output | 1 | Receive interrupt pulse |
| dma_ack_i | input | 1 | Transfer controller has read the data register |

## Verification
A receiver that is out of step with the line shows up about one frame time later: the data register holds the wrong byte, or the full flag never sets. A fault in the flag logic shows up at the very next status read. That covers a lost read-arm, a wrong set priority, or an error lock that never engages or never releases. In those cases a later frame is either stored when it should be dropped or dropped when it should be stored, or `irq_o` pulses the wrong number of times. Each test therefore pairs a frame with the status and data reads that follow it. It also sends one more frame after each recovery step, so that a lock that stays engaged becomes visible.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DATA_W = 8;
  localparam int SRX_ADDR_W = 2;

  localparam logic [SRX_ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [SRX_ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [SRX_ADDR_W-1:0] A_DATA = 2'd2;

  localparam int B_FULL = 0;
  localparam int B_OVR  = 1;
  localparam int B_PER  = 2;
  localparam int B_FER  = 3;
  localparam int B_LINE = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [SRX_DATA_W-1:0] data;
    logic                  par_err;
    logic                  frm_err;
  } rx_result_t;
endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en_i)            cnt_d = div_i;
    else if (cnt_q == '0) cnt_d = div_i;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && (cnt_q == '0);

  // R2: ticks are spaced by the divider
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = SRX_DATA_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic       done_o,
  output rx_result_t result_o
);
  localparam int OSR_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [OSR_W-1:0] HALF_LAST = OSR_W'(OSR / 2 - 1);
  localparam logic [OSR_W-1:0] FULL_LAST = OSR_W'(OSR - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [OSR_W-1:0]  tcnt_q, tcnt_d;
  logic [BIT_W-1:0]  bcnt_q, bcnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              par_q, par_d;
  logic              done_q, done_d;
  rx_result_t        res_q, res_d;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    shift_d = shift_q;
    par_d   = par_q;
    done_d  = 1'b0;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!rxd_i) begin
          state_d = ST_START;
          tcnt_d  = '0;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (tcnt_q == HALF_LAST) begin
            tcnt_d = '0;
            bcnt_d = '0;
            par_d  = 1'b0;
            state_d = rxd_i ? ST_IDLE : ST_DATA;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          if (tcnt_q == FULL_LAST) begin
            tcnt_d  = '0;
            shift_d = {rxd_i, shift_q[DATA_W-1:1]};
            par_d   = par_q ^ rxd_i;
            if (bcnt_q == BIT_LAST) state_d = par_en_i ? ST_PAR : ST_STOP;
            else                    bcnt_d  = bcnt_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (tick_i) begin
          if (tcnt_q == FULL_LAST) begin
            tcnt_d  = '0;
            par_d   = par_q ^ rxd_i;
            state_d = ST_STOP;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick_i) begin
          if (tcnt_q == FULL_LAST) begin
            tcnt_d        = '0;
            done_d        = 1'b1;
            res_d.data    = shift_q;
            res_d.frm_err = !rxd_i;
            res_d.par_err = par_en_i && (par_q != par_odd_i);
            state_d       = ST_IDLE;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (!en_i) begin
      state_d = ST_IDLE;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      shift_q <= shift_d;
      par_q   <= par_d;
      done_q  <= done_d;
      res_q   <= res_d;
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;

  // R11: a start bit seen high again at mid-bit returns to idle
  p_glitch_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && state_q == ST_START && tick_i && tcnt_q == HALF_LAST && rxd_i)
      |=> state_q == ST_IDLE);
  // R10: disabled receiver stays idle and reports nothing
  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state_q == ST_IDLE && !done_o));
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int ADDR_W = SRX_ADDR_W,
  parameter int DATA_W = SRX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dma_ack_i,
  input  logic              done_i,
  input  rx_result_t        result_i,
  input  logic              line_i,
  output logic              rx_en_o,
  output logic              par_en_o,
  output logic              par_odd_o,
  output logic              irq_o
);
  localparam int NFLAG = 4;

  logic [2:0]        ctrl_q, ctrl_d;
  logic [NFLAG-1:0]  flags_q, flags_d;
  logic [NFLAG-1:0]  arm_q, arm_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              irq_q, irq_d;

  logic             stat_wr, stat_rd, ctrl_wr;
  logic [NFLAG-1:0] clr_mask, set_mask;
  logic             err_any, accept, clean;

  assign stat_wr  = wr_i && (addr_i == A_STAT);
  assign stat_rd  = rd_i && (addr_i == A_STAT);
  assign ctrl_wr  = wr_i && (addr_i == A_CTRL);
  assign err_any  = flags_q[B_OVR] | flags_q[B_PER] | flags_q[B_FER];
  assign accept   = done_i && ctrl_q[0] && !err_any;
  assign clean    = !result_i.frm_err && !result_i.par_err;

  always_comb begin
    clr_mask = stat_wr ? (arm_q & ~wdata_i[NFLAG-1:0]) : '0;
    if (dma_ack_i) clr_mask[B_FULL] = 1'b1;
    set_mask          = '0;
    set_mask[B_FULL]  = accept && clean && !flags_q[B_FULL];
    set_mask[B_OVR]   = accept && clean && flags_q[B_FULL];
    set_mask[B_PER]   = accept && !result_i.frm_err && result_i.par_err;
    set_mask[B_FER]   = accept && result_i.frm_err;
  end

  always_comb begin
    flags_d = set_mask | (flags_q & ~clr_mask);
    arm_d   = (stat_rd ? flags_q : arm_q) & flags_d & ~set_mask;
    data_d  = set_mask[B_FULL] ? result_i.data : data_q;
    irq_d   = set_mask[B_FULL];
    ctrl_d  = ctrl_wr ? wdata_i[2:0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      arm_q   <= '0;
      data_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      flags_q <= flags_d;
      arm_q   <= arm_d;
      data_q  <= data_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[2:0] = ctrl_q;
      A_STAT: begin
        rdata_o[NFLAG-1:0] = flags_q;
        rdata_o[B_LINE]    = line_i;
      end
      A_DATA: rdata_o = data_q;
      default: rdata_o = '0;
    endcase
  end

  assign rx_en_o   = ctrl_q[0];
  assign par_en_o  = ctrl_q[1];
  assign par_odd_o = ctrl_q[2];
  assign irq_o     = irq_q;

  // R3: interrupt only on a rising full flag
  p_irq_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_q[B_FULL] && !$past(flags_q[B_FULL])));
  // R4: writing ones leaves every flag as it was
  p_wr1_noeffect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata_i[NFLAG-1:0] == '1 && !dma_ack_i && !done_i)
      |=> flags_q == $past(flags_q));
  // R5: overrun keeps the stored byte
  p_overrun_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clean && flags_q[B_FULL]) |=> (flags_q[B_OVR] && $stable(data_q)));
  // R6: any error flag locks the data register
  p_error_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && err_any) |=> ($stable(data_q) && !irq_o));
  // R9: controller acknowledge drops the full flag
  p_dma_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack_i && !done_i) |=> !flags_q[B_FULL]);
endmodule

// File: rtl/srx_channel.sv
module srx_channel
  import srx_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic [1:0]       addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             irq_o,
  input  logic             dma_ack_i
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic       rxd_s, tick, done;
  logic       rx_en, par_en, par_odd;
  rx_result_t result;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else if (g == 0) sync_q[g] <= rxd_i;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign rxd_s = sync_q[SYNC_STAGES-1];

  srx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (rx_en),
    .div_i  (baud_div_i),
    .tick_o (tick)
  );

  srx_frame #(.OSR(OSR), .DATA_W(SRX_DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (rx_en),
    .tick_i    (tick),
    .rxd_i     (rxd_s),
    .par_en_i  (par_en),
    .par_odd_i (par_odd),
    .done_o    (done),
    .result_o  (result)
  );

  srx_regs #(.ADDR_W(SRX_ADDR_W), .DATA_W(SRX_DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .dma_ack_i (dma_ack_i),
    .done_i    (done),
    .result_i  (result),
    .line_i    (rxd_s),
    .rx_en_o   (rx_en),
    .par_en_o  (par_en),
    .par_odd_o (par_odd),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/srx_channel_tb.sv
module srx_channel_tb;
  localparam int BIT_CYC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [15:0] div = 16'd3;
  logic [1:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int vec = 0, miss = 0, irq_cnt = 0;

  always #10 clk = ~clk;

  srx_channel u_dut (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .baud_div_i(div),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .dma_ack_i(ack)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk); rxd = b;
    repeat (BIT_CYC - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pen, input logic odd,
                      input logic badpar, input logic stopb);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (pen) drive_bit(^d ^ odd ^ badpar);
    drive_bit(stopb);
    @(negedge clk); rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic clear_all();
    logic [7:0] s;
    bus_rd(2'd1, s);
    bus_wr(2'd1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    bus_rd(2'd1, d); chk("R1 status", d, 8'h80);
    bus_rd(2'd2, d); chk("R1 data", d, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    send(8'h5E, 0, 0, 0, 1);
    bus_rd(2'd1, d); chk("R10 status while disabled", d, 8'h80);
    bus_rd(2'd2, d); chk("R10 data while disabled", d, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    int i0 = irq_cnt;
    bus_wr(2'd0, 8'h01);
    send(8'hA5, 0, 0, 0, 1);
    bus_rd(2'd1, d); chk("R2 full set", d, 8'h81);
    bus_rd(2'd2, d); chk("R2 data", d, 8'hA5);
    chk("R3 one irq pulse", irq_cnt - i0, 1);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, d); chk("R4 full cleared", d, 8'h80);
  endtask

  task automatic t_clear_rules();
    logic [7:0] d;
    send(8'h3C, 0, 0, 0, 1);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, d); chk("R4 write 0 without read", d, 8'h81);
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, d); chk("R4 write 1 no effect", d, 8'h81);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, d); chk("R4 read then write 0", d, 8'h80);
  endtask

  task automatic t_overrun_lock();
    logic [7:0] d;
    int i0;
    send(8'h44, 0, 0, 0, 1);
    send(8'h11, 0, 0, 0, 1);
    bus_rd(2'd1, d); chk("R5 overrun flag", d, 8'h83);
    bus_rd(2'd2, d); chk("R5 data kept", d, 8'h44);
    bus_wr(2'd1, 8'h02);
    i0 = irq_cnt;
    send(8'h22, 0, 0, 0, 1);
    bus_rd(2'd1, d); chk("R6 locked status", d, 8'h82);
    bus_rd(2'd2, d); chk("R6 locked data", d, 8'h44);
    chk("R6 no irq while locked", irq_cnt - i0, 0);
    bus_wr(2'd1, 8'h00);
    send(8'h33, 0, 0, 0, 1);
    bus_rd(2'd1, d); chk("R6 resumes after clear", d, 8'h81);
    bus_rd(2'd2, d); chk("R6 resumed data", d, 8'h33);
    clear_all();
  endtask

  task automatic t_parity();
    logic [7:0] d;
    bus_wr(2'd0, 8'h03);
    send(8'h5A, 1, 0, 0, 1);
    bus_rd(2'd1, d); chk("R7 even ok", d, 8'h81);
    bus_rd(2'd2, d); chk("R7 even data", d, 8'h5A);
    bus_wr(2'd1, 8'h00);
    send(8'h5B, 1, 0, 1, 1);
    bus_rd(2'd1, d); chk("R7 even mismatch", d, 8'h84);
    bus_rd(2'd2, d); chk("R7 byte not stored", d, 8'h5A);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h07);
    send(8'hC3, 1, 1, 0, 1);
    bus_rd(2'd1, d); chk("R7 odd ok", d, 8'h81);
    bus_rd(2'd2, d); chk("R7 odd data", d, 8'hC3);
    bus_wr(2'd1, 8'h00);
    send(8'hC3, 1, 1, 1, 1);
    bus_rd(2'd1, d); chk("R7 odd mismatch", d, 8'h84);
    clear_all();
    bus_wr(2'd0, 8'h01);
  endtask

  task automatic t_framing();
    logic [7:0] d;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(i[0]);
    drive_bit(1'b0);
    repeat (20) @(negedge clk);
    bus_rd(2'd1, d); chk("R8 R12 framing with line low", d, 8'h08);
    bus_rd(2'd2, d); chk("R8 byte not stored", d, 8'hC3);
    @(negedge clk); rxd = 1'b1;
    repeat (12 * BIT_CYC) @(negedge clk);
    bus_rd(2'd1, d); chk("R12 line high again", d, 8'h88);
    clear_all();
    bus_rd(2'd1, d); chk("R8 cleared", d, 8'h80);
  endtask

  task automatic t_dma();
    logic [7:0] d;
    send(8'h96, 0, 0, 0, 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    bus_rd(2'd1, d); chk("R9 ack clears full", d, 8'h80);
    bus_rd(2'd2, d); chk("R9 data", d, 8'h96);
  endtask

  task automatic t_glitch();
    logic [7:0] d;
    int i0 = irq_cnt;
    @(negedge clk); rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT_CYC) @(negedge clk);
    bus_rd(2'd1, d); chk("R11 glitch ignored", d, 8'h80);
    chk("R11 no irq", irq_cnt - i0, 0);
    send(8'h0F, 0, 0, 0, 1);
    bus_rd(2'd2, d); chk("R11 recovers", d, 8'h0F);
    clear_all();
  endtask

  task automatic t_continuous();
    logic [7:0] d, s;
    send(8'h6D, 0, 0, 0, 1);
    fork
      send(8'h77, 0, 0, 0, 1);
      begin
        repeat (4 * BIT_CYC) @(negedge clk);
        bus_rd(2'd1, s);
        bus_rd(2'd2, d);
        chk("R13 first byte", d, 8'h6D);
        bus_wr(2'd1, 8'h00);
      end
    join
    bus_rd(2'd1, d); chk("R13 no overrun", d, 8'h81);
    bus_rd(2'd2, d); chk("R13 second byte", d, 8'h77);
    clear_all();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_clear_rules();
    t_overrun_lock();
    t_parity();
    t_framing();
    t_dma();
    t_glitch();
    t_continuous();
    summary();
  end
endmodule